// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status-Tagged Receive Queue

This block turns an asynchronous serial line into characters. It waits in idle on a high line and treats a falling line as a candidate start bit. It accepts the start bit only if the line is still low at the middle of the bit, and then samples each later bit once per bit period. A single-cycle enable supplied from outside sets the bit period, with sixteen enables to one bit. Characters are 8 or 9 bits wide, sent least significant bit first, with an optional even or odd parity bit. The first stop bit ends the frame. Any further stop bits are treated as ordinary idle line.

Each completed character goes into a small queue together with its own ninth bit and its framing, parity and overrun flags, so status can never drift away from the character it describes. The consumer sees the oldest entry on the outputs. It reads the ninth bit and the flags first, then pulses the pop input, which stands for reading the low data byte and removes the entry. When a character completes while the queue is full, the character is dropped and the overrun flag is set on the entry stored last.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the queue is empty: `rx_valid` is 0 and `rx_data`, `rx_bit8`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: A low level in idle starts a frame only if the line is still low after 8 oversampling enables. If the line is high at that sample, the receiver returns to idle and stores nothing.
- R3: After the start bit, one bit is sampled every 16 enables, least significant bit first. There are 8 data bits when `cfg_nine` is 0 and 9 when it is 1. The sample of the first stop bit completes the frame and stores one entry.
- R4: The receiver does not check any stop bit after the first. A frame with two stop bits is stored without error, and a frame that directly follows it is received correctly.
- R5: With `cfg_nine` = 1 the ninth data bit appears on `rx_bit8`. With `cfg_nine` = 0, `rx_bit8` is 0.
- R6: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd` = 0 the ones across all data bits and the parity bit must be even in number, and with `cfg_par_odd` = 1 they must be odd. A mismatch sets `err_parity` on that entry. With `cfg_par_en` = 0, `err_parity` is 0.
- R7: A low first stop bit sets `err_frame` on that entry. The receiver then waits for a high line before it looks for a new start bit.
- R8: The queue holds 2 entries. A frame that completes while the queue is full, with no pop in the same cycle, is discarded, and `err_overrun` is set on the entry stored last.
- R9: The outputs show the oldest entry while `rx_valid` is 1. A pulse on `rx_pop` removes that entry. A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 expects a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_pop | input | 1 | Reads the low data byte and removes the oldest entry |
| rx_valid | output | 1 | Queue holds at least one entry |
| rx_data | output | 8 | Low 8 data bits of the oldest entry |
| rx_bit8 | output | 1 | Ninth data bit of the oldest entry |
| err_frame | output | 1 | Framing error flag of the oldest entry |
| err_parity | output | 1 | Parity error flag of the oldest entry |
| err_overrun | output | 1 | Overrun flag of the oldest entry |

## Verification
The assertions assume that the three configuration inputs stay constant for the whole of a frame, that `os_tick` is never high in two consecutive cycles, and that `rxd` holds each bit for about sixteen enables. The stimulus changes configuration only while the line is idle and no frame is in progress. It generates the enable as one pulse every four clocks and holds every bit for exactly sixty-four clocks. The only deliberately short level is the start-bit glitch used for R2, which is over well before the mid-bit sample.

// File: rtl/uart_rx_tagged_pkg.sv
package uart_rx_tagged_pkg;

    // One queue entry: data plus the status that belongs to it.
    typedef struct packed {
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic       bit8;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAITHI
    } rx_state_t;

    // Parity bit value the sender must place for the given character.
    function automatic logic want_parity(input logic [8:0] d,
                                         input logic nine,
                                         input logic odd);
        logic [8:0] used;
        used = nine ? d : {1'b0, d[7:0]};
        return (^used) ^ odd;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_tagged_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      os_tick,
    input  logic      rxd_s,
    input  logic      cfg_nine,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

    rx_state_t      state;
    logic [CW-1:0]  cnt;
    logic [3:0]     idx;
    logic [8:0]     sr;
    logic           par_bit;
    logic           bit_edge;
    logic [3:0]     last_idx;

    assign bit_edge = os_tick && (cnt == LAST_CNT);
    assign last_idx = cfg_nine ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            sr      <= '0;
            par_bit <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (os_tick && state != RX_IDLE && state != RX_WAITHI) begin
                cnt <= (state == RX_START && cnt == MID_CNT) ? '0 : cnt + 1'b1;
            end
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                    if (!rxd_s) state <= RX_START;
                end
                RX_START: begin
                    if (os_tick && cnt == MID_CNT) begin
                        state <= rxd_s ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (bit_edge) begin
                        sr[idx] <= rxd_s;
                        if (idx == last_idx) begin
                            idx   <= '0;
                            state <= cfg_par_en ? RX_PAR : RX_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (bit_edge) begin
                        par_bit <= rxd_s;
                        state   <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (bit_edge) begin
                        push       <= 1'b1;
                        entry.data <= sr[7:0];
                        entry.bit8 <= cfg_nine & sr[8];
                        entry.ferr <= ~rxd_s;
                        entry.perr <= cfg_par_en &
                                      (par_bit != want_parity(sr, cfg_nine, cfg_par_odd));
                        entry.ovr  <= 1'b0;
                        state      <= rxd_s ? RX_IDLE : RX_WAITHI;
                    end
                end
                RX_WAITHI: begin
                    if (rxd_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R3: each frame yields exactly one single-cycle store request.
    a_r3_single_push: assert property (@(posedge clk) disable iff (rst)
        push |=> !push);

    // R2: a high line in idle never opens a frame.
    a_r2_no_false_start: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && rxd_s) |=> state != RX_START);

    // R7: after a low stop bit the receiver holds off until the line is high.
    a_r7_wait_high: assert property (@(posedge clk) disable iff (rst)
        (state == RX_WAITHI && !rxd_s) |=> state == RX_WAITHI);

    // R3: a store request only follows the stop-bit state.
    a_r3_push_from_stop: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(state) == RX_STOP);
endmodule

// File: rtl/rx_tag_queue.sv
module rx_tag_queue
    import uart_rx_tagged_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t wr_entry,
    input  logic      pop,
    output logic      not_empty,
    output rx_entry_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, newest_ptr;
    logic [CW-1:0] count;
    logic          full, do_pop, do_push, ovr_hit;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full       = (count == FULL_CNT);
    assign not_empty  = (count != '0);
    assign do_pop     = pop && not_empty;
    assign do_push    = push && (!full || do_pop);
    assign ovr_hit    = push && full && !do_pop;
    assign newest_ptr = (wr_ptr == '0) ? LAST_PTR : wr_ptr - 1'b1;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[g] <= '0;
                end else if (do_push && wr_ptr == PW'(g)) begin
                    mem[g] <= wr_entry;
                end else if (ovr_hit && newest_ptr == PW'(g)) begin
                    mem[g].ovr <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = not_empty ? mem[rd_ptr] : '0;

    // R8: occupancy never exceeds the configured depth.
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    // R8: a dropped frame leaves the queue full and the write slot unmoved.
    a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
        ovr_hit |=> (full && $stable(wr_ptr)));

    // R9: popping an empty queue with nothing arriving leaves it empty.
    a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (pop && !not_empty && !push) |=> !not_empty);

    // R9: a pop with no arrival shrinks the queue by one.
    a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (pop && not_empty && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_tagged_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int QUEUE_DEPTH = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       cfg_nine,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rx_pop,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    logic      rxd_s;
    logic      frame_push;
    rx_entry_t frame_entry;
    rx_entry_t head;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_framer #(.OSR(OSR)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .os_tick     (os_tick),
        .rxd_s       (rxd_s),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push        (frame_push),
        .entry       (frame_entry)
    );

    rx_tag_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (frame_push),
        .wr_entry  (frame_entry),
        .pop       (rx_pop),
        .not_empty (rx_valid),
        .head      (head)
    );

    assign rx_data     = head.data;
    assign rx_bit8     = head.bit8;
    assign err_frame   = head.ferr;
    assign err_parity  = head.perr;
    assign err_overrun = head.ovr;

    // R9: an empty queue presents all-zero data and status.
    a_r9_empty_outputs_zero: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> (rx_data == 8'h00 && !rx_bit8 && !err_frame &&
                       !err_parity && !err_overrun));

    // R5: in 8-bit mode a newly stored entry never carries a ninth bit.
    a_r5_no_bit8_in_byte_mode: assert property (@(posedge clk) disable iff (rst)
        (frame_push && !cfg_nine) |-> !frame_entry.bit8);
endmodule

// File: tb/uart_rx_tagged_tb.sv
`timescale 1ns/1ps
module uart_rx_tagged_tb;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_nine = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rx_pop = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_bit8, err_frame, err_parity, err_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit auto_rd  = 1'b1;
    bit stray_req = 1'b0;
    bit done     = 1'b0;
    int tdiv     = 0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        os_tick <= (tdiv == TICK_DIV - 1);
    end

    uart_rx_tagged u_dut (
        .clk         (clk),
        .rst         (rst),
        .os_tick     (os_tick),
        .rxd         (rxd),
        .cfg_nine    (cfg_nine),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rx_pop      (rx_pop),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_bit8     (rx_bit8),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_overrun (err_overrun)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Expected entry layout: {ovr, perr, ferr, bit8, data}.
    task automatic expect_item(input logic [7:0] d, input logic b8,
                               input logic fe, input logic pe,
                               input logic ov, input string tag);
        exp_q.push_back({ov, pe, fe, b8, d});
        tag_q.push_back(tag);
    endtask

    task automatic send_frame(input logic [8:0] d, input int stops,
                              input bit flip_par, input bit bad_stop);
        int nb;
        logic p;
        nb = cfg_nine ? 9 : 8;
        p  = (^(cfg_nine ? d : {1'b0, d[7:0]})) ^ cfg_par_odd ^ flip_par;
        rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        if (cfg_par_en) begin
            rxd = p;
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = bad_stop ? 1'b0 : 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        if (stops > 1) repeat (BIT_CLK * (stops - 1)) @(negedge clk);
    endtask

    task automatic drain(input int limit);
        int w;
        w = 0;
        while (exp_q.size() != 0 && w < limit) begin
            @(negedge clk);
            w++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares the head entry against the scoreboard, then pops it.
    initial begin
        logic [11:0] got;
        forever begin
            @(negedge clk);
            if (!rst && auto_rd && rx_valid) begin
                got = {err_overrun, err_parity, err_frame, rx_bit8, rx_data};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected entry", 32'(got), 32'h0);
                end else begin
                    string t;
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, 32'(got), 32'(e));
                end
                rx_pop = 1'b1;
                @(negedge clk);
                rx_pop = 1'b0;
            end else if (stray_req) begin
                rx_pop = 1'b1;
                @(negedge clk);
                rx_pop = 1'b0;
                stray_req = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rx_valid == 1'b0, "R1 rx_valid after reset", 32'(rx_valid), 32'h0);
        check(rx_data == 8'h00, "R1 rx_data after reset", 32'(rx_data), 32'h0);
        check({rx_bit8, err_frame, err_parity, err_overrun} == 4'b0,
              "R1 status after reset",
              32'({rx_bit8, err_frame, err_parity, err_overrun}), 32'h0);
        repeat (BIT_CLK) @(negedge clk);

        // R3: plain 8-bit frames, LSB first
        expect_item(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, "R3 byte A5");
        send_frame(9'h0A5, 1, 1'b0, 1'b0);
        expect_item(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R3 byte 01");
        send_frame(9'h001, 1, 1'b0, 1'b0);
        drain(2000);

        // R2: a short low glitch is not a start bit
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        check(rx_valid == 1'b0, "R2 glitch stored nothing", 32'(rx_valid), 32'h0);
        expect_item(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R2 frame after glitch");
        send_frame(9'h03C, 1, 1'b0, 1'b0);
        drain(2000);

        // R6: even and odd parity, good and bad
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        expect_item(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, "R6 even parity good");
        send_frame(9'h081, 1, 1'b0, 1'b0);
        expect_item(8'h81, 1'b0, 1'b0, 1'b1, 1'b0, "R6 even parity bad");
        send_frame(9'h081, 1, 1'b1, 1'b0);
        drain(2000);
        cfg_par_odd = 1'b1;
        expect_item(8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, "R6 odd parity good");
        send_frame(9'h07E, 1, 1'b0, 1'b0);
        expect_item(8'h7E, 1'b0, 1'b0, 1'b1, 1'b0, "R6 odd parity bad");
        send_frame(9'h07E, 1, 1'b1, 1'b0);
        drain(2000);

        // R5: nine-bit characters, with and without parity
        cfg_nine = 1'b1;
        expect_item(8'hF3, 1'b1, 1'b0, 1'b0, 1'b0, "R5 nine-bit odd parity");
        send_frame(9'h1F3, 1, 1'b0, 1'b0);
        cfg_par_en = 1'b0;
        drain(2000);
        expect_item(8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, "R5 nine-bit no parity");
        send_frame(9'h10F, 1, 1'b0, 1'b0);
        expect_item(8'hC2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 nine-bit top clear");
        send_frame(9'h0C2, 1, 1'b0, 1'b0);
        drain(2000);
        cfg_nine = 1'b0;
        expect_item(8'h55, 1'b0, 1'b0, 1'b0, 1'b0, "R5 bit8 zero in byte mode");
        send_frame(9'h055, 1, 1'b0, 1'b0);
        drain(2000);

        // R7: low stop bit
        expect_item(8'h96, 1'b0, 1'b1, 1'b0, 1'b0, "R7 frame error");
        send_frame(9'h096, 1, 1'b0, 1'b1);
        repeat (BIT_CLK) @(negedge clk);
        expect_item(8'h69, 1'b0, 1'b0, 1'b0, 1'b0, "R7 clean frame after error");
        send_frame(9'h069, 1, 1'b0, 1'b0);
        drain(2000);

        // R4: two stop bits, next frame right behind
        expect_item(8'hE1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 two stop bits");
        send_frame(9'h0E1, 2, 1'b0, 1'b0);
        expect_item(8'h1E, 1'b0, 1'b0, 1'b0, 1'b0, "R4 frame after two stops");
        send_frame(9'h01E, 2, 1'b0, 1'b0);
        drain(2000);

        // R8: overrun with the consumer stalled
        auto_rd = 1'b0;
        send_frame(9'h011, 1, 1'b0, 1'b0);
        send_frame(9'h022, 1, 1'b0, 1'b0);
        send_frame(9'h033, 1, 1'b0, 1'b0);
        repeat (8) @(negedge clk);
        check(rx_valid == 1'b1, "R8 queue holds entries", 32'(rx_valid), 32'h1);
        check(rx_data == 8'h11, "R8 oldest entry at head", 32'(rx_data), 32'h11);
        expect_item(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, "R8 first entry kept");
        expect_item(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, "R8 overrun on newest");
        auto_rd = 1'b1;
        drain(200);
        check(rx_valid == 1'b0, "R8 third frame discarded", 32'(rx_valid), 32'h0);

        // R9: pop on empty queue has no effect
        stray_req = 1'b1;
        repeat (6) @(negedge clk);
        check(rx_valid == 1'b0, "R9 empty pop ignored", 32'(rx_valid), 32'h0);
        check({rx_data, err_overrun} == 9'h0, "R9 empty outputs zero",
              32'({rx_data, err_overrun}), 32'h0);
        expect_item(8'hBD, 1'b0, 1'b0, 1'b0, 1'b0, "R9 frame after empty pop");
        send_frame(9'h0BD, 1, 1'b0, 1'b0);
        drain(2000);

        check(exp_q.size() == 0, "R3 all expected entries seen",
              32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule